// File: doc/BRIEF.md
# Timed Stop-State Power Controller

This block moves a processor-style core into a timed low-power stop state when software writes to it. A single 32-bit control word holds a stop-duration count, a change-mode bit, a voltage-control enable, a two-bit bus-divisor mode, a pending divisor value and a pending 5-bit voltage code. Writing a non-zero count starts a stop interval of `count * 2^SCALE_LOG2` bus clocks. The default scale is 4096.

New voltage and divisor settings are not applied when they are written. They are committed only on the clock edge where a stop interval begins, and the mode bits select what is committed. The voltage-ID pins show a fixed code from reset onward. The effective divisor starts out as the value of the strap pins, captured while reset is asserted. A `stop_active` level marks the interval, and a one-cycle `stop_done` pulse marks its end.

Top module: `stop_grant_ctl`

## Requirements
- R1: While `rst_n` is low, `vid_out` is 5'b01010, `stop_active` and `stop_done` are 0, and every stored field is 0 except the voltage code, which is 5'b01010. At the first clock after reset, `div_out` holds the value `strap_div` had on the last clock edge with `rst_n` low.
- R2: `rd_data` returns 0 in bits 31..12. Bits 11..0 return the stored fields: bit 11 change mode, bit 10 voltage enable, bits 9..8 divisor mode, bits 7..5 divisor value, bits 4..0 voltage code.
- R3: A write whose count field (bits 31..12) is zero updates the stored fields only. It leaves `stop_active`, `vid_out` and `div_out` unchanged. This holds for every value of bit 11, including the reserved value 1.
- R4: A write with a non-zero count N, made while no stop interval is active, raises `stop_active` on that clock edge. `stop_active` then stays high for exactly N * 2^SCALE_LOG2 clock cycles.
- R5: `stop_done` is high for exactly one cycle. That cycle is the one immediately after `stop_active` falls.
- R6: On the edge that starts a stop interval, `vid_out` takes the written bits 4..0 if the written bit 10 is 1. Otherwise `vid_out` keeps its value.
- R7: On the edge that starts a stop interval, `div_out` takes the written bits 7..5 if the written divisor mode (bits 9..8) is 2'b10 or 2'b11. For modes 2'b00 and 2'b01, `div_out` keeps its value.
- R8: A write made during an active stop interval updates the stored fields. It does not restart or lengthen the interval, and it does not change `vid_out` or `div_out`.
- R9: Changes on `strap_div` after reset has been released have no effect on `div_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; divisor straps are captured while it is low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value (count field reads zero) |
| strap_div | input | 3 | Divisor strap pins |
| vid_out | output | 5 | Voltage-ID pins |
| div_out | output | 3 | Effective bus divisor |
| stop_active | output | 1 | High throughout a stop interval |
| stop_done | output | 1 | One-cycle pulse at the end of a stop interval |

## Verification
The bench uses a scale of 4 so that it can sweep every combination of voltage enable, all four divisor modes and both change-mode values, with counts from zero to four, against an arithmetic model. A design that commits settings at write time would change the pins on zero-count writes or on writes made during a stop interval. A design that treats the reserved divisor mode 01 like 1x would load the divisor when it should not. A timer that is off by one, or that reloads on a write made mid-interval, would give a high time other than N*4 cycles. After reset, the straps are changed to catch a design that keeps sampling them.

// File: rtl/stop_grant_ctl.sv
module stop_grant_ctl #(
  parameter int SCALE_LOG2 = 12,
  parameter logic [4:0] VID_RST = 5'b01010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [2:0]  strap_div,
  output logic [4:0]  vid_out,
  output logic [2:0]  div_out,
  output logic        stop_active,
  output logic        stop_done
);
  localparam int CNT_W = 20;
  localparam int TMR_W = CNT_W + SCALE_LOG2;

  logic             cmode_q, vctl_q;
  logic [1:0]       dmode_q;
  logic [2:0]       idiv_q;
  logic [4:0]       vcode_q;
  logic [TMR_W-1:0] timer_q;

  wire [CNT_W-1:0] wr_cnt = wr_data[31:12];
  wire start  = wr_en && !stop_active && (wr_cnt != '0);
  wire expire = stop_active && (timer_q == TMR_W'(1));

  assign rd_data = {20'b0, cmode_q, vctl_q, dmode_q, idiv_q, vcode_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode_q <= 1'b0;
      vctl_q  <= 1'b0;
      dmode_q <= 2'b00;
      idiv_q  <= 3'b000;
      vcode_q <= VID_RST;
    end else if (wr_en) begin
      cmode_q <= wr_data[11];
      vctl_q  <= wr_data[10];
      dmode_q <= wr_data[9:8];
      idiv_q  <= wr_data[7:5];
      vcode_q <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_active <= 1'b0;
      stop_done   <= 1'b0;
      timer_q     <= '0;
      vid_out     <= VID_RST;
    end else begin
      stop_done <= expire;
      if (start) begin
        stop_active <= 1'b1;
        timer_q     <= {wr_cnt, {SCALE_LOG2{1'b0}}};
        if (wr_data[10]) vid_out <= wr_data[4:0];
      end else if (expire) begin
        stop_active <= 1'b0;
        timer_q     <= '0;
      end else if (stop_active) begin
        timer_q <= timer_q - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  div_out <= strap_div;
    else if (start && wr_data[9]) div_out <= wr_data[7:5];
  end

  assert_vid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && wr_data[10]) |=> $stable(vid_out));
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && wr_data[9]) |=> $stable(div_out));
  assert_start_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> $past(wr_en));
  assert_end_has_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_active) |-> stop_done);
  assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done);
  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && wr_en) |=> $stable(vid_out) && $stable(div_out));
  assert_count_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[31:12] == 20'b0);
endmodule

// File: tb/stop_grant_ctl_tb.sv
module stop_grant_ctl_tb;
  localparam int SL = 2;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0] strap_div = 3'b101, div_out;
  logic [4:0] vid_out;
  logic stop_active, stop_done;
  int vecs = 0, errs = 0;
  bit finished = 0;

  stop_grant_ctl #(.SCALE_LOG2(SL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .strap_div(strap_div), .vid_out(vid_out), .div_out(div_out),
    .stop_active(stop_active), .stop_done(stop_done));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] word(int n, bit cm, bit vc, logic [1:0] dm,
                                       logic [2:0] id, logic [4:0] vd);
    return {n[19:0], cm, vc, dm, id, vd};
  endfunction

  initial begin
    logic [4:0] evid;
    logic [2:0] ediv;
    logic [31:0] w, w2;
    int dur;
    bit donecnt_ok;
    repeat (3) @(negedge clk);
    check("R1 vid in reset", vid_out, 5'b01010);
    check("R1 active in reset", stop_active, 0);
    check("R1 readback in reset", rd_data, 32'h0000000A);
    rst_n = 1;
    @(negedge clk);
    check("R1 strap captured", div_out, 3'b101);
    strap_div = 3'b010;
    repeat (2) @(negedge clk);
    check("R9 strap ignored", div_out, 3'b101);
    evid = 5'b01010; ediv = 3'b101;
    for (int cfg = 0; cfg < 64; cfg++) begin
      int n = cfg % 5;
      bit vc = cfg[0], cm = cfg[3];
      logic [1:0] dm = cfg[2:1];
      logic [2:0] id = 3'((cfg * 3 + 1) & 7);
      logic [4:0] vd = 5'((cfg * 7 + 3) & 31);
      w = word(n, cm, vc, dm, id, vd);
      wr_en = 1; wr_data = w;
      @(negedge clk);
      wr_en = 0; wr_data = '0;
      check("R2 readback", rd_data, {20'b0, w[11:0]});
      if (n != 0) begin
        if (vc) evid = vd;
        if (dm[1]) ediv = id;
      end
      check("R6 vid commit", vid_out, evid);
      check("R7 div commit", div_out, ediv);
      check(n == 0 ? "R3 zero count stays running" : "R4 stop entered", stop_active, n != 0);
      if (n != 0) begin
        dur = 1;
        w2 = word(7, ~cm, ~vc, ~dm, ~id, ~vd);
        forever begin
          if (dur == 2) begin wr_en = 1; wr_data = w2; end
          @(negedge clk);
          if (dur == 2) begin
            wr_en = 0; wr_data = '0;
            check("R8 fields accepted mid-stop", rd_data, {20'b0, w2[11:0]});
            check("R8 vid unchanged mid-stop", vid_out, evid);
            check("R8 div unchanged mid-stop", div_out, ediv);
          end
          if (!stop_active) break;
          check("R5 no early done", stop_done, 0);
          dur++;
          if (dur > 100) break;
        end
        check("R4/R8 stop duration", dur, n << SL);
        check("R5 done pulse", stop_done, 1);
        @(negedge clk);
        check("R5 done one cycle", stop_done, 0);
        check("R6 vid held after stop", vid_out, evid);
        check("R7 div held after stop", div_out, ediv);
      end else begin
        @(negedge clk);
        check("R3 vid unchanged", vid_out, evid);
        check("R3 div unchanged", div_out, ediv);
        check("R3 no stop", stop_active, 0);
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; vecs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule